// File: doc/BRIEF.md
# SWD Host Transaction Engine

This block is the host side of a two-wire serial debug link. It takes one register access at a time from a controller and runs it on the wire. The access has a read/write flag, a port select that picks the debug port or the access port, a 2-bit register address and 32 bits of write data. The block drives the debug clock. It also drives the data line through an output and an output-enable, and reads the line back through a separate input. The block sends the 8-bit request and releases the line for a programmable number of turnaround periods. It then collects the 3-bit acknowledge. After an accepted acknowledge, it either sends the write word with its parity bit or receives the read word and checks its parity.

Each access ends with a one-cycle completion pulse that carries a status and, for a good read, the data. The first access that does not end well is stored in a sticky error register. While that register holds an error, later accesses are accepted but never reach the wire. They complete at once with a "skipped" status. A flush command sends eight idle clock periods so that a pending access-port operation can drain. It then reports the stored status and clears the register.

Top module: `swd_host_engine`

## Requirements
- R1: The request byte goes out on the wire least significant bit first. Bit 0 is 1. Bit 1 is the port select (1 = access port). Bit 2 is the read flag. Bit 3 is `req_addr[0]` and bit 4 is `req_addr[1]`. Bit 5 is the XOR of bits 1 to 4. Bit 6 is 0 and bit 7 is 1.
- R2: `swclk` idles low, and each high phase lasts `cfg_div`+1 clock cycles. `swdio_o` and `swdio_oe` change only on the edge where `swclk` goes low (or while it stays low). `swdio_i` is sampled on the edge where `swclk` goes high.
- R3: After the request, `swdio_oe` is 0 for `cfg_trn`+1 bit periods. It stays 0 through the acknowledge, through read data and parity, and through a second turnaround of `cfg_trn`+1 periods.
- R4: The acknowledge is received bit 0 first. Pattern 3'b001 means OK, 3'b010 means WAIT and 3'b100 means FAULT. Any other pattern is a protocol error. Status codes are OK=0, WAIT=1, FAULT=2, protocol error=3, parity error=4 and skipped=5. A non-OK acknowledge ends the access after the second turnaround, with no data phase and `done_rdata` = 0.
- R5: On a read with an OK acknowledge, 32 data bits are received LSB first, followed by one parity bit. If the parity bit matches the XOR of the data, the status is OK and `done_rdata` carries the word. Otherwise the status is parity error and `done_rdata` is 0.
- R6: On a write with an OK acknowledge, after the second turnaround the host drives the 32 data bits LSB first, then one bit equal to the XOR of the data.
- R7: Every access-port access that reaches the wire is followed by `cfg_ap_idle` extra bit periods with `swdio_oe`=1 and `swdio_o`=0. Debug-port accesses get none.
- R8: A flush runs exactly 8 idle bit periods. It then completes with the stored sticky status (OK when none is stored) and clears the store.
- R9: The first status other than OK is stored. While a status is stored, any non-flush request is accepted with no `swclk` activity, and `done` rises on the next cycle with status skipped.
- R10: `req_ready` is high only when no access is running and `done` is low. `done` is a single-cycle pulse.
- R11: After reset, `swclk`=0, `swdio_oe`=1, `swdio_o`=0, `req_ready`=1 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine can take a request |
| req_flush | input | 1 | Request is a flush instead of an access |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_apndp | input | 1 | 1 = access port, 0 = debug port |
| req_addr | input | 2 | Register address bits 3:2 |
| req_wdata | input | 32 | Write data |
| cfg_div | input | DIV_W | Clock half-period minus one, in clk cycles |
| cfg_trn | input | TRN_W | Turnaround length minus one, in bit periods |
| cfg_ap_idle | input | IDLE_W | Idle bit periods after an access-port access |
| done | output | 1 | Completion pulse |
| done_status | output | 3 | Completion status code |
| done_rdata | output | 32 | Read data for a good read, else 0 |
| swclk | output | 1 | Debug clock |
| swdio_o | output | 1 | Data line output value |
| swdio_oe | output | 1 | Data line output enable |
| swdio_i | input | 1 | Data line input |

## Verification
On every cycle, the assertions check that the line changes only while the debug clock is low, and that `req_ready` is low whenever the clock rises. They also check that `done` lasts one cycle, that a stored error neither changes nor survives a flush, that a blocked request completes as skipped on the next cycle, and that a failed parity check never hands data out. The bench scenarios are needed for the rest:

- that the request byte is built correctly;
- the lengths of the turnarounds and idle tails under several divider, turnaround and idle settings;
- the decoding of each acknowledge pattern, including a protocol error;
- that write data and its parity arrive intact at a modelled target;
- the full sequence in which an error is stored, a request is skipped and a flush clears the store.

// File: rtl/swd_host_pkg.sv
package swd_host_pkg;

    localparam int SWD_DATA_W = 32;
    localparam int SWD_ACK_W  = 3;
    localparam int SWD_REQ_W  = 8;

    typedef enum logic [2:0] {
        ST_OK     = 3'd0,
        ST_WAIT   = 3'd1,
        ST_FAULT  = 3'd2,
        ST_PROTO  = 3'd3,
        ST_PARITY = 3'd4,
        ST_SKIP   = 3'd5
    } swd_status_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_REQ,
        PH_TRN1,
        PH_ACK,
        PH_RDATA,
        PH_RPAR,
        PH_TRN2,
        PH_WDATA,
        PH_WPAR,
        PH_APIDLE,
        PH_FLUSH
    } swd_phase_e;

    typedef struct packed {
        logic                  flush;
        logic                  rnw;
        logic                  apndp;
        logic [1:0]            addr;
        logic [SWD_DATA_W-1:0] wdata;
    } swd_req_t;

    function automatic logic [SWD_REQ_W-1:0] swd_req_byte(input logic apndp,
                                                          input logic rnw,
                                                          input logic [1:0] addr);
        logic par;
        par = apndp ^ rnw ^ addr[0] ^ addr[1];
        return {1'b1, 1'b0, par, addr[1], addr[0], rnw, apndp, 1'b1};
    endfunction

    function automatic swd_status_e swd_ack_decode(input logic [SWD_ACK_W-1:0] ack);
        case (ack)
            3'b001:  return ST_OK;
            3'b010:  return ST_WAIT;
            3'b100:  return ST_FAULT;
            default: return ST_PROTO;
        endcase
    endfunction

endpackage

// File: rtl/swd_tick_gen.sv
module swd_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             swclk,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt_q;
    logic             tick;

    assign tick = en && (cnt_q == div);
    assign rise = tick && !swclk;
    assign fall = tick && swclk;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
            swclk <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            swclk <= ~swclk;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/swd_sticky_latch.sv
module swd_sticky_latch
    import swd_host_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rec,
    input  swd_status_e rec_status,
    input  logic        clr,
    output swd_status_e err_q
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            err_q <= ST_OK;
        end else if (rec && rec_status != ST_OK && err_q == ST_OK) begin
            err_q <= rec_status;
        end
    end

    // R9: a stored error is held until a flush clears it
    assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (err_q != ST_OK && !clr) |=> (err_q == $past(err_q)));

    // R8: the flush leaves the store empty
    assert_flush_clear_R8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (err_q == ST_OK));
endmodule

// File: rtl/swd_xfer_fsm.sv
module swd_xfer_fsm
    import swd_host_pkg::*;
#(
    parameter int TRN_W      = 2,
    parameter int IDLE_W     = 8,
    parameter int FLUSH_IDLE = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  swd_req_t              req,
    input  logic [TRN_W-1:0]      cfg_trn,
    input  logic [IDLE_W-1:0]     cfg_ap_idle,
    input  logic                  rise,
    input  logic                  fall,
    input  logic                  din,
    output logic                  busy,
    output logic                  dout,
    output logic                  doe,
    output logic                  fin,
    output logic                  fin_flush,
    output swd_status_e           fin_status,
    output logic [SWD_DATA_W-1:0] fin_rdata
);
    localparam int CNT_W = (IDLE_W > 6) ? IDLE_W : 6;

    swd_phase_e              phase, nxt, tail;
    swd_req_t                cur;
    logic [CNT_W-1:0]        cnt, len;
    logic                    last_bit;
    logic [SWD_ACK_W-1:0]    ack_q;
    logic [SWD_DATA_W-1:0]   rdata_q;
    logic                    rpar_q;
    logic                    ack_ok;
    logic [SWD_REQ_W-1:0]    req_byte;
    swd_status_e             status_now;

    assign busy     = (phase != PH_IDLE);
    assign ack_ok   = (ack_q == 3'b001);
    assign req_byte = swd_req_byte(cur.apndp, cur.rnw, cur.addr);
    assign last_bit = (cnt == len - CNT_W'(1));

    always_comb begin
        case (phase)
            PH_REQ:              len = CNT_W'(SWD_REQ_W);
            PH_TRN1, PH_TRN2:    len = CNT_W'(cfg_trn) + CNT_W'(1);
            PH_ACK:              len = CNT_W'(SWD_ACK_W);
            PH_RDATA, PH_WDATA:  len = CNT_W'(SWD_DATA_W);
            PH_APIDLE:           len = CNT_W'(cfg_ap_idle);
            PH_FLUSH:            len = CNT_W'(FLUSH_IDLE);
            default:             len = CNT_W'(1);
        endcase
    end

    always_comb begin
        tail = (cur.apndp && cfg_ap_idle != '0) ? PH_APIDLE : PH_IDLE;
        case (phase)
            PH_REQ:    nxt = PH_TRN1;
            PH_TRN1:   nxt = PH_ACK;
            PH_ACK:    nxt = (ack_ok && cur.rnw) ? PH_RDATA : PH_TRN2;
            PH_RDATA:  nxt = PH_RPAR;
            PH_RPAR:   nxt = PH_TRN2;
            PH_TRN2:   nxt = (ack_ok && !cur.rnw) ? PH_WDATA : tail;
            PH_WDATA:  nxt = PH_WPAR;
            PH_WPAR:   nxt = tail;
            default:   nxt = PH_IDLE;
        endcase
    end

    always_comb begin
        if (cur.flush) begin
            status_now = ST_OK;
        end else begin
            status_now = swd_ack_decode(ack_q);
            if (status_now == ST_OK && cur.rnw && (rpar_q != ^rdata_q))
                status_now = ST_PARITY;
        end
    end

    always_comb begin
        case (phase)
            PH_REQ:   begin doe = 1'b1; dout = req_byte[cnt[2:0]];   end
            PH_WDATA: begin doe = 1'b1; dout = cur.wdata[cnt[4:0]];  end
            PH_WPAR:  begin doe = 1'b1; dout = ^cur.wdata;           end
            PH_TRN1, PH_ACK, PH_RDATA, PH_RPAR, PH_TRN2:
                      begin doe = 1'b0; dout = 1'b0;                 end
            default:  begin doe = 1'b1; dout = 1'b0;                 end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            cur        <= '0;
            cnt        <= '0;
            ack_q      <= '0;
            rdata_q    <= '0;
            rpar_q     <= 1'b0;
            fin        <= 1'b0;
            fin_flush  <= 1'b0;
            fin_status <= ST_OK;
            fin_rdata  <= '0;
        end else begin
            fin <= 1'b0;
            if (phase == PH_IDLE) begin
                if (start) begin
                    cur     <= req;
                    phase   <= req.flush ? PH_FLUSH : PH_REQ;
                    cnt     <= '0;
                    ack_q   <= '0;
                    rdata_q <= '0;
                    rpar_q  <= 1'b0;
                end
            end else begin
                if (rise) begin
                    case (phase)
                        PH_ACK:   ack_q[cnt[1:0]]   <= din;
                        PH_RDATA: rdata_q[cnt[4:0]] <= din;
                        PH_RPAR:  rpar_q            <= din;
                        default:  ;
                    endcase
                end
                if (fall) begin
                    if (!last_bit) begin
                        cnt <= cnt + CNT_W'(1);
                    end else begin
                        cnt   <= '0;
                        phase <= nxt;
                        if (nxt == PH_IDLE) begin
                            fin        <= 1'b1;
                            fin_flush  <= cur.flush;
                            fin_status <= status_now;
                            fin_rdata  <= (status_now == ST_OK && cur.rnw && !cur.flush)
                                          ? rdata_q : '0;
                        end
                    end
                end
            end
        end
    end

    // R5: a read that fails its parity check never hands out data
    assert_parity_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (fin && fin_status == ST_PARITY) |-> (fin_rdata == '0));
endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine
    import swd_host_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int TRN_W      = 2,
    parameter int IDLE_W     = 8,
    parameter int FLUSH_IDLE = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_flush,
    input  logic              req_rnw,
    input  logic              req_apndp,
    input  logic [1:0]        req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [TRN_W-1:0]  cfg_trn,
    input  logic [IDLE_W-1:0] cfg_ap_idle,
    output logic              done,
    output logic [2:0]        done_status,
    output logic [31:0]       done_rdata,
    output logic              swclk,
    output logic              swdio_o,
    output logic              swdio_oe,
    input  logic              swdio_i
);
    logic                  busy, rise, fall;
    logic                  fin, fin_flush;
    swd_status_e           fin_status, err_q;
    logic [SWD_DATA_W-1:0] fin_rdata;
    logic                  accept, skip_now, skip_q, start;
    swd_req_t              req_in;

    assign req_ready = !busy && !done;
    assign accept    = req_valid && req_ready;
    assign skip_now  = accept && !req_flush && (err_q != ST_OK);
    assign start     = accept && !skip_now;

    assign req_in.flush = req_flush;
    assign req_in.rnw   = req_rnw;
    assign req_in.apndp = req_apndp;
    assign req_in.addr  = req_addr;
    assign req_in.wdata = req_wdata;

    always_ff @(posedge clk) begin
        if (rst) skip_q <= 1'b0;
        else     skip_q <= skip_now;
    end

    assign done = fin | skip_q;

    always_comb begin
        if (skip_q)                done_status = ST_SKIP;
        else if (fin && fin_flush) done_status = err_q;
        else                       done_status = fin_status;
    end

    assign done_rdata = fin ? fin_rdata : '0;

    swd_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst   (rst),
        .en    (busy),
        .div   (cfg_div),
        .swclk (swclk),
        .rise  (rise),
        .fall  (fall)
    );

    swd_xfer_fsm #(
        .TRN_W      (TRN_W),
        .IDLE_W     (IDLE_W),
        .FLUSH_IDLE (FLUSH_IDLE)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .req         (req_in),
        .cfg_trn     (cfg_trn),
        .cfg_ap_idle (cfg_ap_idle),
        .rise        (rise),
        .fall        (fall),
        .din         (swdio_i),
        .busy        (busy),
        .dout        (swdio_o),
        .doe         (swdio_oe),
        .fin         (fin),
        .fin_flush   (fin_flush),
        .fin_status  (fin_status),
        .fin_rdata   (fin_rdata)
    );

    swd_sticky_latch u_sticky (
        .clk        (clk),
        .rst        (rst),
        .rec        (fin && !fin_flush),
        .rec_status (fin_status),
        .clr        (fin && fin_flush),
        .err_q      (err_q)
    );

    // R2: the line only moves while the debug clock is low
    assert_dout_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable({swdio_o, swdio_oe}) |-> !swclk);

    // R10: no new request is taken while the clock is running
    assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(swclk) |-> !req_ready);

    // R10: completion is a single-cycle pulse
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: a blocked request completes as skipped on the next cycle
    assert_skip_next_R9: assert property (@(posedge clk) disable iff (rst)
        skip_now |=> (done && done_status == ST_SKIP));
endmodule

// File: tb/sim_swd_host_engine.sv
module sim_swd_host_engine;
    import swd_host_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_flush, req_rnw, req_apndp;
    logic [1:0]  req_addr;
    logic [31:0] req_wdata;
    logic [7:0]  cfg_div;
    logic [1:0]  cfg_trn;
    logic [7:0]  cfg_ap_idle;
    logic        done;
    logic [2:0]  done_status;
    logic [31:0] done_rdata;
    logic        swclk, swdio_o, swdio_oe, swdio_i;

    always #5 clk = ~clk;

    swd_host_engine #(.DIV_W(8), .TRN_W(2), .IDLE_W(8), .FLUSH_IDLE(8)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_flush(req_flush), .req_rnw(req_rnw), .req_apndp(req_apndp),
        .req_addr(req_addr), .req_wdata(req_wdata), .cfg_div(cfg_div),
        .cfg_trn(cfg_trn), .cfg_ap_idle(cfg_ap_idle), .done(done),
        .done_status(done_status), .done_rdata(done_rdata), .swclk(swclk),
        .swdio_o(swdio_o), .swdio_oe(swdio_oe), .swdio_i(swdio_i)
    );

    // ---------------- modelled target on the wire ----------------
    logic [2:0]  t_ack;
    logic [31:0] t_rdata;
    logic        t_badpar;
    logic [7:0]  t_req;
    logic [31:0] t_wdata;
    logic        t_wpar;
    int          t_oe_bad = 0;
    int          edge_cnt = 0;

    always @(posedge swclk) edge_cnt++;

    task automatic slot(input bit drv, input logic v, input logic exp_oe, output logic so);
        @(negedge swclk);
        if (drv) swdio_i = v;
        @(posedge swclk);
        so = swdio_o;
        if (swdio_oe !== exp_oe) t_oe_bad++;
    endtask

    initial begin : target
        logic       s;
        int         trn;
        logic [7:0] rq;
        swdio_i = 1'b0;
        forever begin
            @(posedge swclk);
            if (swdio_oe && swdio_o) begin
                rq = 8'h01;
                for (int i = 1; i < 8; i++) begin slot(0, 1'b0, 1'b1, s); rq[i] = s; end
                t_req = rq;
                trn = int'(cfg_trn) + 1;
                for (int i = 0; i < trn; i++) slot(0, 1'b0, 1'b0, s);
                for (int i = 0; i < 3; i++) slot(1, t_ack[i], 1'b0, s);
                if (t_ack == 3'b001 && rq[2]) begin
                    for (int i = 0; i < 32; i++) slot(1, t_rdata[i], 1'b0, s);
                    slot(1, (^t_rdata) ^ t_badpar, 1'b0, s);
                    for (int i = 0; i < trn; i++) slot(1, 1'b0, 1'b0, s);
                end else if (t_ack == 3'b001) begin
                    for (int i = 0; i < trn; i++) slot(1, 1'b0, 1'b0, s);
                    for (int i = 0; i < 32; i++) begin slot(0, 1'b0, 1'b1, s); t_wdata[i] = s; end
                    slot(0, 1'b0, 1'b1, s);
                    t_wpar = s;
                end else begin
                    for (int i = 0; i < trn; i++) slot(1, 1'b0, 1'b0, s);
                end
                swdio_i = 1'b0;
            end
        end
    end

    // ---------------- per-clock wire monitor (R2) ----------------
    int   m_run = 0, m_fail = 0, hi_len = 0;
    logic prev_o, prev_oe;

    always @(negedge clk) begin
        if (rst) begin
            hi_len  = 0;
            prev_o  = swdio_o;
            prev_oe = swdio_oe;
        end else begin
            if (swclk && (swdio_o !== prev_o || swdio_oe !== prev_oe)) begin
                m_run++; m_fail++;
                $display("FAIL R2 line moved while swclk high: act=%b%b exp=%b%b",
                         swdio_o, swdio_oe, prev_o, prev_oe);
            end
            if (swclk) hi_len++;
            else if (hi_len != 0) begin
                m_run++;
                if (hi_len != int'(cfg_div) + 1) begin
                    m_fail++;
                    $display("FAIL R2 high phase length act=%0d exp=%0d", hi_len, int'(cfg_div) + 1);
                end
                hi_len = 0;
            end
            prev_o  = swdio_o;
            prev_oe = swdio_oe;
        end
    end

    // ---------------- scoreboard ----------------
    int          n_run = 0, n_fail = 0;
    swd_status_e m_sticky = ST_OK;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic fl, input logic rnw, input logic ap, input logic [1:0] ad,
                        input logic [31:0] wd, input logic [2:0] ack, input logic [31:0] rd,
                        input logic bp);
        swd_status_e es;
        logic [31:0] er;
        logic [7:0]  eb;
        int          ee, trn, base_e, base_oe;
        bit          wire_acc;
        trn = int'(cfg_trn) + 1;
        er = '0;
        wire_acc = 1'b0;
        if (fl) begin
            es = m_sticky; ee = 8; m_sticky = ST_OK;
        end else if (m_sticky != ST_OK) begin
            es = ST_SKIP; ee = 0;
        end else begin
            wire_acc = 1'b1;
            case (ack)
                3'b001:  es = ST_OK;
                3'b010:  es = ST_WAIT;
                3'b100:  es = ST_FAULT;
                default: es = ST_PROTO;
            endcase
            ee = 8 + trn + 3 + trn + ((es == ST_OK) ? 33 : 0) + (ap ? int'(cfg_ap_idle) : 0);
            if (es == ST_OK && rnw && bp) es = ST_PARITY;
            if (es == ST_OK && rnw) er = rd;
            if (es != ST_OK) m_sticky = es;
        end
        eb = {1'b1, 1'b0, ap ^ rnw ^ ad[0] ^ ad[1], ad[1], ad[0], rnw, ap, 1'b1};
        t_ack = ack; t_rdata = rd; t_badpar = bp;
        base_e = edge_cnt; base_oe = t_oe_bad;
        @(negedge clk);
        req_flush = fl; req_rnw = rnw; req_apndp = ap; req_addr = ad; req_wdata = wd;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        check(done_status == es, "R4/R8/R9 status", done_status, es);
        check(done_rdata == er, "R5 read data", done_rdata, er);
        check(!req_ready, "R10 ready low during done", req_ready, 0);
        @(negedge clk);
        check(!done, "R10 done single pulse", done, 0);
        check(edge_cnt - base_e == ee, "R7/R8/R9 swclk periods", edge_cnt - base_e, ee);
        check(t_oe_bad == base_oe, "R3 turnaround release", t_oe_bad - base_oe, 0);
        if (wire_acc) check(t_req == eb, "R1 request byte", t_req, eb);
        if (wire_acc && !rnw && ack == 3'b001) begin
            check(t_wdata == wd, "R6 write data", t_wdata, wd);
            check(t_wpar == ^wd, "R6 write parity", t_wpar, ^wd);
        end
    endtask

    initial begin : main
        rst = 1'b1; req_valid = 1'b0; req_flush = 1'b0; req_rnw = 1'b0; req_apndp = 1'b0;
        req_addr = 2'd0; req_wdata = '0; cfg_div = 8'd0; cfg_trn = 2'd0; cfg_ap_idle = 8'd0;
        t_ack = 3'b001; t_rdata = '0; t_badpar = 1'b0;
        repeat (4) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(swclk == 1'b0, "R11 swclk", swclk, 0);
        check(swdio_oe == 1'b1 && swdio_o == 1'b0, "R11 line idle", {swdio_oe, swdio_o}, 2'b10);
        check(req_ready == 1'b1 && done == 1'b0, "R11 handshake", {req_ready, done}, 2'b10);

        // R5 R1: debug-port read, fastest clock, single turnaround
        xfer(0, 1, 0, 2'd0, 32'h0, 3'b001, 32'hA5A5_1234, 0);
        // R6: debug-port write
        xfer(0, 0, 0, 2'd2, 32'hDEAD_BEEF, 3'b001, 32'h0, 0);
        // R7 R3: access-port read, divider 2, two-period turnaround, 3 idle periods
        cfg_div = 8'd2; cfg_trn = 2'd1; cfg_ap_idle = 8'd3;
        xfer(0, 1, 1, 2'd3, 32'h0, 3'b001, 32'h8000_0001, 0);
        // R6 R7: access-port write, four-period turnaround
        cfg_div = 8'd1; cfg_trn = 2'd3; cfg_ap_idle = 8'd5;
        xfer(0, 0, 1, 2'd1, 32'h1357_9BDF, 3'b001, 32'h0, 0);
        // R4 R9 R8: WAIT is stored, next access skipped, flush reports and clears
        cfg_div = 8'd0; cfg_trn = 2'd0;
        xfer(0, 1, 1, 2'd1, 32'h0, 3'b010, 32'hFFFF_FFFF, 0);
        xfer(0, 0, 0, 2'd2, 32'h1111_2222, 3'b001, 32'h0, 0);
        xfer(1, 0, 0, 2'd0, 32'h0, 3'b001, 32'h0, 0);
        xfer(1, 0, 0, 2'd0, 32'h0, 3'b001, 32'h0, 0);
        // R5: parity mismatch drops data
        xfer(0, 1, 0, 2'd1, 32'h0, 3'b001, 32'h0F0F_00FF, 1);
        xfer(1, 0, 0, 2'd0, 32'h0, 3'b001, 32'h0, 0);
        // R4: FAULT on a write, no data phase
        cfg_trn = 2'd2;
        xfer(0, 0, 0, 2'd3, 32'hCAFE_F00D, 3'b100, 32'h0, 0);
        xfer(1, 0, 0, 2'd0, 32'h0, 3'b001, 32'h0, 0);
        // R4: unknown pattern is a protocol error; following write skipped
        xfer(0, 1, 1, 2'd2, 32'h0, 3'b111, 32'h0, 0);
        xfer(0, 0, 1, 2'd2, 32'h4444_5555, 3'b001, 32'h0, 0);
        xfer(1, 0, 0, 2'd0, 32'h0, 3'b001, 32'h0, 0);
        // R5: clean read after recovery, second stored error kept first (R9)
        cfg_div = 8'd3; cfg_trn = 2'd0; cfg_ap_idle = 8'd0;
        xfer(0, 1, 1, 2'd1, 32'h0, 3'b001, 32'h7654_3210, 0);
        xfer(0, 1, 0, 2'd0, 32'h0, 3'b100, 32'h0, 0);
        xfer(0, 1, 0, 2'd0, 32'h0, 3'b010, 32'h0, 0);
        xfer(1, 0, 0, 2'd0, 32'h0, 3'b001, 32'h0, 0);

        repeat (5) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run + m_run, n_fail + m_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired act=hung exp=finished");
        $display("[TB] %0d tests run, %0d failed", n_run + m_run + 1, n_fail + m_fail + 1);
        $finish;
    end
endmodule